// File: doc/BRIEF.md
# Timestamped Packet Source and Sink for One Network Node

This block produces and consumes test traffic for a single node of an on-chip network. A scheduler issues a burst of fixed-length packets. The gap between packet starts is a programmable number of cycles, and that gap sets the offered load. The first packet of each burst is held back by a pseudo-random part of one gap, so that nodes started together do not inject in step.

Each packet is stamped with its departure time when it is generated. The stamp is then queued as a small descriptor before a serializer turns it into flits on the outgoing valid/ready link. Any wait caused by a congested link therefore shows up in the measured latency.

The sink takes flits from the node's local output. It checks the packet length and the sequence order. For each packet that arrives intact, it adds the arrival time minus the departure stamp to a running sum and increments a packet count.

The scheduler walks through five states:
- SC_IDLE: waits for a start pulse; start goes to SC_OFFSET.
- SC_OFFSET: counts down the random offset, then moves to SC_ISSUE.
- SC_ISSUE: pushes a descriptor. From here it goes to SC_GAP, or to SC_DONE after the last packet, or it stays in SC_ISSUE while the queue is full.
- SC_GAP: counts down the gap, then moves to SC_ISSUE.
- SC_DONE: holds until a new start, which goes to SC_OFFSET.

The serializer moves TX_IDLE → TX_HEAD → TX_BODY → TX_IDLE. The sink alternates between RX_HEAD and RX_BODY.

Top module: `traffic_node`

## Requirements
- R1: After reset, tx_valid, gen_done, pkt_count, lat_sum, seq_err and len_err are all 0, and rx_ready is 1.
- R2: Every accepted start produces exactly PKTS (default 50) packets of FLITS (default 8) flits on the tx link. tx_last is 1 on the final flit of each packet and only there. gen_done rises after the last packet of the burst is generated. A flit offered while tx_ready is low stays unchanged.
- R3: The head flit carries the packet sequence number in bits [31:24] and the 24-bit departure timestamp in bits [23:0]. The timestamp is the number of clock cycles since reset, modulo 2^24. Sequence numbers start at 0 after reset and go up by 1 per packet, continuing across bursts. Body flit k (k = 1..FLITS-1) carries the sequence number in [31:24], k in [23:16] and zero in [15:0].
- R4: When start is sampled at cycle g, the first packet of the burst has timestamp g + o + 2. Here o = (L × gap) >> 16, and L is the state of a 16-bit shift register. L starts at SEED after reset and advances once per accepted start: shift left, with new bit 0 = b15 ^ b13 ^ b12 ^ b10.
- R5: With the link always ready and gap ≥ 10, consecutive packets of a burst have timestamps exactly gap apart. The gap value is sampled when start is accepted.
- R6: A packet that falls due while the descriptor queue is full is generated later rather than dropped, and its timestamp is the cycle in which it is actually generated. Consecutive timestamps are never closer than gap.
- R7: A start pulse during a running burst has no effect: the burst length, the sequence numbers and the next burst's offset are unchanged.
- R8: For each well-formed packet, lat_sum increases by (cycle at which its head flit is accepted − head timestamp) modulo 2^24.
- R9: pkt_count increases by 1 when the last flit of a well-formed packet (exactly FLITS flits, tx_last only on the final one) is accepted.
- R10: A head flit whose sequence number differs from the previous head's number + 1 (modulo 256; 0 is expected first) sets seq_err, which stays set until reset. That packet is still counted if it is well-formed.
- R11: A packet that ends before FLITS flits, or has no last mark on flit FLITS, sets the sticky len_err. It adds nothing to pkt_count or lat_sum.
- R12: rx_ready is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a burst |
| gap | input | 16 | Cycles between packet starts, sampled at start |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Outgoing link can accept a flit |
| tx_data | output | 32 | Outgoing flit |
| tx_last | output | 1 | Outgoing flit ends its packet |
| rx_valid | input | 1 | Incoming flit valid |
| rx_ready | output | 1 | Sink accepts a flit, always 1 |
| rx_data | input | 32 | Incoming flit |
| rx_last | input | 1 | Incoming flit ends its packet |
| gen_done | output | 1 | Burst fully generated |
| pkt_count | output | 16 | Well-formed packets received |
| lat_sum | output | 32 | Sum of packet latencies in cycles |
| seq_err | output | 1 | Sticky sequence-gap flag |
| len_err | output | 1 | Sticky packet-length flag |

## Verification
Three back-to-back bursts with different gaps are looped from the link output to the sink, with a start pulse dropped into the middle of one burst. Exact gap spacing and a fixed two-cycle latency separate correct scheduling from off-by-one counts, and the offsets of the later bursts show whether the shift register advanced on the ignored pulse. A long backpressure window fills the descriptor queue, which separates delayed generation from dropped packets. Flits driven directly into the sink, including a wrapped timestamp, a skipped sequence number and packets that are too short or too long, separate the latency arithmetic from the two error flags.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
    localparam int FLIT_W = 32;
    localparam int SEQ_W  = 8;
    localparam int TS_W   = 24;
    localparam int LFSR_W = 16;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [TS_W-1:0]  ts;
    } desc_t;

    typedef enum logic [2:0] {SC_IDLE, SC_OFFSET, SC_GAP, SC_ISSUE, SC_DONE} sched_e;
    typedef enum logic [1:0] {TX_IDLE, TX_HEAD, TX_BODY} tx_e;
    typedef enum logic       {RX_HEAD, RX_BODY} rx_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/tg_fifo.sv
module tg_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    used;

    assign full    = used == CW'(DEPTH);
    assign empty   = used == '0;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (wr_en && !rd_en)      used <= used + CW'(1);
            else if (rd_en && !wr_en) used <= used - CW'(1);
        end
    end

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty);
endmodule

// File: rtl/tg_sched.sv
module tg_sched import tgen_pkg::*; #(
    parameter int                PKTS  = 50,
    parameter int                GAP_W = 16,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] gap,
    input  logic [TS_W-1:0]  now,
    input  logic             full,
    output logic             push,
    output desc_t            push_desc,
    output logic             done
);
    localparam int                PK_W    = $clog2(PKTS + 1);
    localparam logic [LFSR_W-1:0] SEED_NZ = (SEED == '0) ? LFSR_W'(1) : SEED;

    sched_e                    st, st_nx;
    logic [GAP_W-1:0]          cnt, gap_q, offset, gap_m2;
    logic [LFSR_W-1:0]         lfsr;
    logic [SEQ_W-1:0]          seq;
    logic [PK_W-1:0]           pk;
    logic [LFSR_W+GAP_W-1:0]   prod;
    logic                      accept_go, last_pkt;

    // offset is a fraction L/2^16 of one gap
    assign prod      = {{GAP_W{1'b0}}, lfsr} * {{LFSR_W{1'b0}}, gap};
    assign offset    = GAP_W'(prod >> LFSR_W);
    assign gap_m2    = (gap_q < GAP_W'(2)) ? '0 : gap_q - GAP_W'(2);
    assign last_pkt  = pk == PK_W'(PKTS - 1);
    assign push_desc = '{seq: seq, ts: now};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SC_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx     = st;
        push      = 1'b0;
        done      = 1'b0;
        accept_go = 1'b0;
        unique case (st)
            SC_IDLE, SC_DONE: begin
                done = (st == SC_DONE);
                if (start) begin
                    accept_go = 1'b1;
                    st_nx     = SC_OFFSET;
                end
            end
            SC_OFFSET, SC_GAP: begin
                if (cnt == '0) st_nx = SC_ISSUE;
            end
            SC_ISSUE: begin
                if (!full) begin
                    push  = 1'b1;
                    st_nx = last_pkt ? SC_DONE : SC_GAP;
                end
            end
            default: st_nx = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            gap_q <= '0;
            lfsr  <= SEED_NZ;
            seq   <= '0;
            pk    <= '0;
        end else if (accept_go) begin
            cnt   <= offset;
            gap_q <= gap;
            lfsr  <= lfsr_step(lfsr);
            pk    <= '0;
        end else if (push) begin
            cnt <= gap_m2;
            seq <= seq + SEQ_W'(1);
            pk  <= pk + PK_W'(1);
        end else if ((st == SC_OFFSET || st == SC_GAP) && cnt != '0) begin
            cnt <= cnt - GAP_W'(1);
        end
    end

    // R2: a finished burst stays finished until a new start
    a_r2_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SC_DONE && !start) |=> (st == SC_DONE));
    // R7: a start during a burst leaves the sampled gap alone
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st != SC_IDLE && st != SC_DONE) |=> $stable(gap_q));
endmodule

// File: rtl/tg_tx.sv
module tg_tx import tgen_pkg::*; #(
    parameter int FLITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              empty,
    input  desc_t             rd_desc,
    output logic              pop,
    output logic              tx_valid,
    output logic [FLIT_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    localparam int IW = $clog2(FLITS);

    tx_e           st, st_nx;
    desc_t         hold;
    logic [IW-1:0] idx;
    logic          body_end;

    assign body_end = idx == IW'(FLITS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx    = st;
        pop      = 1'b0;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_data  = '0;
        unique case (st)
            TX_IDLE: begin
                if (!empty) begin
                    pop   = 1'b1;
                    st_nx = TX_HEAD;
                end
            end
            TX_HEAD: begin
                tx_valid = 1'b1;
                tx_data  = hold;
                if (tx_ready) st_nx = TX_BODY;
            end
            TX_BODY: begin
                tx_valid = 1'b1;
                tx_last  = body_end;
                tx_data  = {hold.seq, 8'(idx), {(FLIT_W - SEQ_W - 8){1'b0}}};
                if (tx_ready && body_end) st_nx = TX_IDLE;
            end
            default: st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            idx  <= '0;
        end else begin
            if (pop) hold <= rd_desc;
            if (st == TX_HEAD && tx_ready)                  idx <= IW'(1);
            else if (st == TX_BODY && tx_ready && !body_end) idx <= idx + IW'(1);
        end
    end

    // R2: a flit waiting on the link does not change
    a_r2_hold_flit: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

// File: rtl/tg_rx.sv
module tg_rx import tgen_pkg::*; #(
    parameter int FLITS = 8,
    parameter int CNT_W = 16,
    parameter int SUM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now,
    input  logic              rx_valid,
    input  logic [FLIT_W-1:0] rx_data,
    input  logic              rx_last,
    output logic [CNT_W-1:0]  pkt_count,
    output logic [SUM_W-1:0]  lat_sum,
    output logic              seq_err,
    output logic              len_err
);
    localparam int FW = $clog2(FLITS) + 1;

    rx_e              st, st_nx;
    logic [SEQ_W-1:0] exp_seq;
    logic [TS_W-1:0]  lat_hold;
    logic [FW-1:0]    fcnt;
    logic             bad, at_end, good_end, len_hit, seq_hit;
    logic [SEQ_W-1:0] in_seq;
    logic [TS_W-1:0]  in_ts;

    assign in_seq = rx_data[FLIT_W-1 -: SEQ_W];
    assign in_ts  = rx_data[TS_W-1:0];
    assign at_end = fcnt == FW'(FLITS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_HEAD;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx    = st;
        good_end = 1'b0;
        len_hit  = 1'b0;
        seq_hit  = 1'b0;
        unique case (st)
            RX_HEAD: begin
                if (rx_valid) begin
                    seq_hit = in_seq != exp_seq;
                    len_hit = rx_last;
                    if (!rx_last) st_nx = RX_BODY;
                end
            end
            RX_BODY: begin
                if (rx_valid) begin
                    if (rx_last) begin
                        good_end = at_end && !bad;
                        len_hit  = !at_end;
                        st_nx    = RX_HEAD;
                    end else begin
                        len_hit = at_end;
                    end
                end
            end
            default: st_nx = RX_HEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_seq   <= '0;
            lat_hold  <= '0;
            fcnt      <= '0;
            bad       <= 1'b0;
            pkt_count <= '0;
            lat_sum   <= '0;
            seq_err   <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            if (st == RX_HEAD && rx_valid) begin
                exp_seq  <= in_seq + SEQ_W'(1);
                lat_hold <= now - in_ts;
                fcnt     <= FW'(1);
                bad      <= 1'b0;
            end else if (st == RX_BODY && rx_valid && !rx_last) begin
                if (at_end) bad  <= 1'b1;
                else        fcnt <= fcnt + FW'(1);
            end
            if (good_end) begin
                pkt_count <= pkt_count + CNT_W'(1);
                lat_sum   <= lat_sum + SUM_W'(lat_hold);
            end
            if (seq_hit) seq_err <= 1'b1;
            if (len_hit) len_err <= 1'b1;
        end
    end

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pkt_count) |-> (pkt_count == $past(pkt_count) + CNT_W'(1)));
    a_r8_sum_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_sum) |-> !$stable(pkt_count));
    a_r10_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);
    a_r11_len_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);
endmodule

// File: rtl/traffic_node.sv
module traffic_node import tgen_pkg::*; #(
    parameter int                PKTS   = 50,
    parameter int                FLITS  = 8,
    parameter int                QDEPTH = 4,
    parameter int                GAP_W  = 16,
    parameter int                CNT_W  = 16,
    parameter int                SUM_W  = 32,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GAP_W-1:0]  gap,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [FLIT_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [FLIT_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              gen_done,
    output logic [CNT_W-1:0]  pkt_count,
    output logic [SUM_W-1:0]  lat_sum,
    output logic              seq_err,
    output logic              len_err
);
    localparam int DW = $bits(desc_t);

    logic [TS_W-1:0] now;
    logic            q_push, q_pop, q_full, q_empty;
    desc_t           q_in, q_out;
    logic [DW-1:0]   q_out_raw;

    assign rx_ready = 1'b1;
    assign q_out    = desc_t'(q_out_raw);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now <= '0;
        else        now <= now + TS_W'(1);
    end

    tg_sched #(.PKTS(PKTS), .GAP_W(GAP_W), .SEED(SEED)) u_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .gap(gap), .now(now),
        .full(q_full), .push(q_push), .push_desc(q_in), .done(gen_done)
    );

    tg_fifo #(.WIDTH(DW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(q_push), .wr_data(q_in),
        .rd_en(q_pop), .rd_data(q_out_raw), .full(q_full), .empty(q_empty)
    );

    tg_tx #(.FLITS(FLITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .empty(q_empty), .rd_desc(q_out), .pop(q_pop),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    tg_rx #(.FLITS(FLITS), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .now(now), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .pkt_count(pkt_count), .lat_sum(lat_sum),
        .seq_err(seq_err), .len_err(len_err)
    );
endmodule

// File: tb/traffic_node_test.sv
`timescale 1ns/1ps
module traffic_node_test;
    localparam logic [15:0] SEED = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] gap = 16'd20;
    logic        gate = 1'b1;
    logic        lb = 1'b1;
    logic        d_valid = 1'b0;
    logic        d_last = 1'b0;
    logic [31:0] d_data = '0;

    logic        tx_valid, tx_last, rx_ready, gen_done, seq_err, len_err;
    logic [31:0] tx_data, lat_sum;
    logic [15:0] pkt_count;

    wire         rx_v = lb ? (tx_valid & gate) : d_valid;
    wire  [31:0] rx_d = lb ? tx_data : d_data;
    wire         rx_l = lb ? tx_last : d_last;

    traffic_node #(.SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .gap(gap),
        .tx_valid(tx_valid), .tx_ready(gate), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_v), .rx_ready(rx_ready), .rx_data(rx_d), .rx_last(rx_l),
        .gen_done(gen_done), .pkt_count(pkt_count), .lat_sum(lat_sum),
        .seq_err(seq_err), .len_err(len_err)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    logic [23:0] tb_now;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_now <= '0;
        else        tb_now <= tb_now + 24'd1;
    end

    // link monitor (loopback mode)
    logic [23:0] head_ts  [0:255];
    logic [7:0]  head_seq [0:255];
    int          n_heads, n_lasts, fmt_bad, bidx;
    logic [7:0]  cur_seq;
    longint      exp_lat;

    always @(posedge clk) begin
        if (lb && tx_valid && gate) begin
            if (bidx == 0) begin
                head_ts[n_heads]  = tx_data[23:0];
                head_seq[n_heads] = tx_data[31:24];
                cur_seq           = tx_data[31:24];
                exp_lat          += longint'(24'(tb_now - tx_data[23:0]));
                n_heads++;
                if (tx_last) fmt_bad++;
                bidx = 1;
            end else begin
                if (tx_data[31:24] != cur_seq || tx_data[23:16] != 8'(bidx) || tx_data[15:0] != 16'h0)
                    fmt_bad++;
                if (tx_last != (bidx == 7)) fmt_bad++;
                if (tx_last) begin
                    bidx = 0;
                    n_lasts++;
                end else begin
                    bidx++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_heads = 0; n_lasts = 0; fmt_bad = 0; bidx = 0; exp_lat = 0; cur_seq = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; d_valid = 1'b0; d_last = 1'b0; gate = 1'b1;
        clr_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic longint offs(input logic [15:0] l, input logic [15:0] g);
        return (longint'(l) * longint'(g)) >> 16;
    endfunction

    task automatic pulse_start(input logic [15:0] g, output logic [23:0] t);
        @(negedge clk);
        gap = g; start = 1'b1; t = tb_now;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!gen_done) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic send_pkt(input logic [7:0] sq, input logic [23:0] lat, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            d_valid = 1'b1;
            d_last  = (i == n - 1);
            d_data  = (i == 0) ? {sq, 24'(tb_now - lat)} : {sq, 8'(i), 16'h0};
        end
        @(negedge clk);
        d_valid = 1'b0; d_last = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_valid == 0, "R1", "tx_valid in reset", tx_valid, 0);
        chk(gen_done == 0, "R1", "gen_done in reset", gen_done, 0);
        chk(pkt_count == 0 && lat_sum == 0, "R1", "counters in reset", pkt_count + lat_sum, 0);
        chk(!seq_err && !len_err, "R1", "flags in reset", seq_err + len_err, 0);
        chk(rx_ready == 1, "R12", "rx_ready in reset", rx_ready, 1);
    endtask

    task automatic check_burst(input int base, input logic [15:0] g, input logic [23:0] gt,
                               input logic [15:0] l, input string tag);
        int bad_gap = 0, bad_seq = 0;
        chk(n_heads == base + 50, "R2", {tag, " packet count on link"}, n_heads, base + 50);
        chk(longint'(24'(head_ts[base] - gt)) == offs(l, g) + 2, "R4", {tag, " first departure"},
            24'(head_ts[base] - gt), offs(l, g) + 2);
        for (int i = base; i < base + 50; i++) begin
            if (head_seq[i] != 8'(i)) bad_seq++;
            if (i > base && 24'(head_ts[i] - head_ts[i-1]) != 24'(g)) bad_gap++;
        end
        chk(bad_seq == 0, "R3", {tag, " sequence numbering"}, bad_seq, 0);
        chk(bad_gap == 0, "R5", {tag, " packet spacing"}, bad_gap, 0);
    endtask

    task automatic t_bursts();
        logic [23:0] gt;
        do_reset();
        lb = 1'b1;
        pulse_start(16'd20, gt);
        wait_done();
        check_burst(0, 16'd20, gt, SEED, "burst1");
        chk(n_lasts == 50 && fmt_bad == 0, "R2", "last marks and flit format", fmt_bad, 0);
        chk(pkt_count == 50, "R9", "received count burst1", pkt_count, 50);
        chk(lat_sum == 32'(exp_lat) && exp_lat == 100, "R8", "latency sum burst1", lat_sum, 100);

        pulse_start(16'd37, gt);
        while (n_heads < 70) @(negedge clk);
        begin
            logic [23:0] dummy;
            pulse_start(16'd5, dummy);   // R7: must be ignored
        end
        wait_done();
        check_burst(50, 16'd37, gt, nxt(SEED), "burst2");
        chk(pkt_count == 100, "R7", "busy start left burst length", pkt_count, 100);

        pulse_start(16'd23, gt);
        wait_done();
        check_burst(100, 16'd23, gt, nxt(nxt(SEED)), "burst3");
        chk(pkt_count == 150 && fmt_bad == 0, "R9", "received count burst3", pkt_count, 150);
        chk(lat_sum == 32'(exp_lat), "R8", "latency sum three bursts", lat_sum, exp_lat);
        chk(!seq_err && !len_err, "R10", "no errors on clean loopback", seq_err + len_err, 0);
    endtask

    task automatic t_backpressure();
        logic [23:0] gt;
        logic [31:0] held;
        int short_gap = 0, long_gap = 0, bad_seq = 0;
        do_reset();
        lb = 1'b1;
        pulse_start(16'd10, gt);
        while (n_heads < 5) @(negedge clk);
        gate = 1'b0;
        repeat (5) @(negedge clk);
        held = tx_data;
        repeat (150) @(negedge clk);
        chk(tx_valid && tx_data == held, "R2", "flit held under backpressure", tx_data, held);
        repeat (150) @(negedge clk);
        gate = 1'b1;
        wait_done();
        repeat (100) @(negedge clk);
        for (int i = 0; i < n_heads; i++) begin
            if (head_seq[i] != 8'(i)) bad_seq++;
            if (i > 0 && 24'(head_ts[i] - head_ts[i-1]) < 24'd10) short_gap++;
            if (i > 0 && 24'(head_ts[i] - head_ts[i-1]) > 24'd10) long_gap++;
        end
        chk(n_heads == 50 && bad_seq == 0, "R6", "no packet dropped", n_heads, 50);
        chk(short_gap == 0, "R6", "spacing never below gap", short_gap, 0);
        chk(long_gap > 0, "R6", "generation was delayed", long_gap, 1);
        chk(pkt_count == 50, "R9", "count after stall", pkt_count, 50);
        chk(lat_sum == 32'(exp_lat) && exp_lat > 100, "R8", "latency includes queueing", lat_sum, exp_lat);
    endtask

    task automatic t_direct_latency();
        do_reset();
        lb = 1'b0;
        send_pkt(8'd0, 24'd37, 8);
        send_pkt(8'd1, 24'd5, 8);
        repeat (2) @(negedge clk);
        chk(pkt_count == 2, "R9", "direct count", pkt_count, 2);
        chk(lat_sum == 42, "R8", "direct latency sum", lat_sum, 42);
        send_pkt(8'd2, 24'hFFFFFD, 8);
        repeat (2) @(negedge clk);
        chk(lat_sum == 32'd16777255, "R8", "wrapped timestamp", lat_sum, 16777255);
        chk(!seq_err && !len_err, "R10", "clean direct packets", seq_err + len_err, 0);
        chk(rx_ready == 1, "R12", "rx_ready during traffic", rx_ready, 1);
    endtask

    task automatic t_seq_gap();
        do_reset();
        lb = 1'b0;
        send_pkt(8'd0, 24'd1, 8);
        send_pkt(8'd2, 24'd1, 8);
        repeat (2) @(negedge clk);
        chk(seq_err == 1, "R10", "skipped sequence flagged", seq_err, 1);
        chk(pkt_count == 2 && lat_sum == 2, "R10", "gap packet still counted", pkt_count, 2);
        chk(len_err == 0, "R11", "no length error on gap", len_err, 0);
    endtask

    task automatic t_len();
        do_reset();
        lb = 1'b0;
        send_pkt(8'd0, 24'd4, 5);
        repeat (2) @(negedge clk);
        chk(len_err == 1, "R11", "short packet flagged", len_err, 1);
        chk(pkt_count == 0 && lat_sum == 0, "R11", "short packet not counted", pkt_count + lat_sum, 0);
        send_pkt(8'd1, 24'd6, 8);
        repeat (2) @(negedge clk);
        chk(pkt_count == 1 && lat_sum == 6, "R11", "good packet after short one", lat_sum, 6);
        chk(seq_err == 0, "R10", "sequence kept after short packet", seq_err, 0);
        do_reset();
        send_pkt(8'd0, 24'd4, 9);
        repeat (2) @(negedge clk);
        chk(len_err == 1, "R11", "long packet flagged", len_err, 1);
        chk(pkt_count == 0 && lat_sum == 0, "R11", "long packet not counted", pkt_count + lat_sum, 0);
    endtask

    initial begin
        clr_mon();
        t_reset();
        t_bursts();
        t_backpressure();
        t_direct_latency();
        t_seq_gap();
        t_len();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule